// File: doc/BRIEF.md
# I2C Serial Clock Divider

This block produces the serial clock for an I2C master from the system clock. An 8-bit control word selects the rate and the mode. A 5-bit divider code and a standard/fast select set the length of the low and high phases. One bit enables an acknowledge clock after each byte. Another bit holds the level the master returns during that acknowledge clock; the block only stores this bit and presents it to the neighbouring data shifter.

A start request begins one byte transfer. The block runs 8 data clocks, plus a 9th acknowledge clock when that clock is enabled, and then returns to idle with SCL released. SCL is driven as an open-drain pull-down enable. The block also gives the neighbouring shifter three one-cycle markers:
- a fall pulse where SDA may change;
- a rise pulse where SDA is sampled;
- a bit-done pulse after each bit's high phase.

A stop request, or any write to the control word, aborts the transfer at once. Clock stretching, multi-master synchronisation and START/STOP condition generation are handled elsewhere.

Top module: `i2c_sclk_div`

## Requirements
- R1: In standard mode (control bit 5 = 0), SCL is pulled low for 4 × code cycles and released for 4 × code cycles of every bit, where code = control bits 4:0.
- R2: In fast mode (bit 5 = 1) with a code other than 5, the low phase and the high phase each last 2 × code cycles.
- R3: In fast mode with code 5, the low phase lasts 6 cycles and the high phase lasts 4 cycles, for a period of 10 cycles.
- R4: While the stored code is 0, 1 or 2, a start request is ignored, SCL stays released and `cfg_error` goes to 1. A write of such a code also sets `cfg_error`. The flag stays set until the next write, which leaves it at 1 only if that write is also illegal.
- R5: A control write resets the generator. From the cycle after the write, `xfer_busy` and `scl_pull_low` are 0 and no pulse appears. A write wins over a start request in the same cycle and over a phase boundary in the same cycle.
- R6: A transfer runs 8 clocks when control bit 7 = 0 and 9 clocks when bit 7 = 1. `ack_clock_slot` is high for all low and high cycles of the 9th clock and never during an 8-clock transfer.
- R7: `scl_fall_pulse` is high in the first pulled-low cycle of each bit. `scl_rise_pulse` is high in the first released cycle. `bit_done_pulse` is high in the cycle after each bit's high phase, so it coincides with the next bit's fall pulse or with the first idle cycle.
- R8: A stop request during a transfer returns the block to idle with SCL released from the next cycle.
- R9: `ack_level` always equals control bit 6 of the last write.
- R10: After reset the control word is 0, the block is idle, SCL is released, all pulses are 0 and `cfg_error` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_wdata | input | 8 | Control word: bits 4:0 code, 5 fast mode, 6 ACK level, 7 ACK clock enable |
| ctl_we | input | 1 | Control word write strobe |
| xfer_start | input | 1 | Request to start one byte of clocks |
| xfer_stop | input | 1 | Request to abort the running transfer |
| scl_pull_low | output | 1 | 1 = pull SCL low, 0 = release |
| scl_rise_pulse | output | 1 | One-cycle marker of SCL release |
| scl_fall_pulse | output | 1 | One-cycle marker of SCL pull-down |
| bit_done_pulse | output | 1 | One-cycle marker of the end of a bit |
| xfer_busy | output | 1 | A transfer is running |
| ack_clock_slot | output | 1 | The 9th (acknowledge) clock is running |
| ack_level | output | 1 | Stored ACK level bit |
| cfg_error | output | 1 | Sticky illegal-code flag |

## Verification
A control write can land in the same cycle as a bit boundary, where the generator would otherwise emit a bit-done pulse and the next fall pulse. The bench provokes this by timing the write strobe to the exact edge that ends the first bit's high phase in a fast code-3 transfer. It then checks that the cycle after that edge shows neither pulse, with SCL released and the block idle. A start request in the same cycle as a write is provoked the same way, and the block must stay idle.

// File: rtl/i2c_sclk_pkg.sv
package i2c_sclk_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } phase_e;

   function automatic int unsigned ceil_log2(input int unsigned val);
      int unsigned r;
      r = 0;
      while ((1 << r) < val) r++;
      return (r == 0) ? 1 : r;
   endfunction

endpackage

// File: rtl/sclk_ctl_reg.sv
module sclk_ctl_reg #(
   parameter int CODE_W   = 5,
   parameter int MIN_CODE = 3,
   localparam int CTL_W   = CODE_W + 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CTL_W-1:0]  wdata,
   input  logic              we,
   input  logic              start_req,
   output logic [CODE_W-1:0] code,
   output logic              fast,
   output logic              ack_lvl,
   output logic              ack_en,
   output logic              legal,
   output logic              err
);

   logic [CTL_W-1:0] ctl_q;
   logic             err_q;
   logic             new_illegal;

   if (MIN_CODE < 1 || MIN_CODE >= (1 << CODE_W)) begin : g_min_chk
      $error("sclk_ctl_reg: MIN_CODE outside code range");
   end

   assign new_illegal = wdata[CODE_W-1:0] < CODE_W'(MIN_CODE);

   always_ff @(posedge clk) begin
      if (rst) begin
         ctl_q <= '0;
         err_q <= 1'b0;
      end else if (we) begin
         ctl_q <= wdata;
         err_q <= new_illegal;
      end else if (start_req && !legal) begin
         err_q <= 1'b1;
      end
   end

   assign code    = ctl_q[CODE_W-1:0];
   assign fast    = ctl_q[CODE_W];
   assign ack_lvl = ctl_q[CODE_W+1];
   assign ack_en  = ctl_q[CODE_W+2];
   assign legal   = code >= CODE_W'(MIN_CODE);
   assign err     = err_q;

   // R4
   err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (err_q && !we) |=> err_q);

   // R9
   lvl_follow_chk: assert property (@(posedge clk) disable iff (rst)
      we |=> (ack_lvl == $past(wdata[CODE_W+1])));

endmodule

// File: rtl/sclk_phase_calc.sv
module sclk_phase_calc #(
   parameter int CODE_W       = 5,
   parameter int STD_MULT     = 8,
   parameter int FAST_MULT    = 4,
   parameter bit SPECIAL_EN   = 1'b1,
   parameter int SPECIAL_CODE = 5,
   parameter int SPECIAL_LOW  = 6,
   parameter int SPECIAL_HIGH = 4,
   parameter int CNT_W        = 7
) (
   input  logic [CODE_W-1:0] code,
   input  logic              fast,
   output logic [CNT_W-1:0]  low_len,
   output logic [CNT_W-1:0]  high_len
);

   localparam int STD_HALF  = STD_MULT / 2;
   localparam int FAST_HALF = FAST_MULT / 2;

   if ((STD_MULT % 2) != 0 || (FAST_MULT % 2) != 0) begin : g_even_chk
      $error("sclk_phase_calc: multipliers must be even");
   end
   if (SPECIAL_EN && (SPECIAL_LOW + SPECIAL_HIGH != 2 * SPECIAL_CODE)) begin : g_spec_chk
      $error("sclk_phase_calc: special phases must sum to 2 x code");
   end

   logic [CNT_W-1:0] half_len;

   always_comb begin
      if (fast) half_len = CNT_W'(FAST_HALF) * CNT_W'(code);
      else      half_len = CNT_W'(STD_HALF) * CNT_W'(code);
   end

   if (SPECIAL_EN) begin : g_special
      logic is_special;
      assign is_special = fast && (code == CODE_W'(SPECIAL_CODE));
      assign low_len  = is_special ? CNT_W'(SPECIAL_LOW)  : half_len;
      assign high_len = is_special ? CNT_W'(SPECIAL_HIGH) : half_len;
   end else begin : g_plain
      assign low_len  = half_len;
      assign high_len = half_len;
   end

endmodule

// File: rtl/sclk_bit_seq.sv
module sclk_bit_seq
   import i2c_sclk_pkg::*;
#(
   parameter int DATA_BITS = 8,
   parameter int CNT_W     = 7,
   localparam int BIT_W    = ceil_log2(DATA_BITS + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             abort,
   input  logic             start,
   input  logic             legal,
   input  logic             ack_en,
   input  logic [CNT_W-1:0] low_len,
   input  logic [CNT_W-1:0] high_len,
   output logic             scl_low,
   output logic             rise_p,
   output logic             fall_p,
   output logic             bit_end_p,
   output logic             busy,
   output logic             ack_slot
);

   phase_e           ph_q;
   logic [CNT_W-1:0] cnt_q;
   logic [BIT_W-1:0] bit_q;
   logic [BIT_W-1:0] last_bit;

   if (DATA_BITS < 1) begin : g_bits_chk
      $error("sclk_bit_seq: DATA_BITS must be positive");
   end

   assign last_bit = ack_en ? BIT_W'(DATA_BITS) : BIT_W'(DATA_BITS - 1);

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q      <= PH_IDLE;
         cnt_q     <= '0;
         bit_q     <= '0;
         scl_low   <= 1'b0;
         rise_p    <= 1'b0;
         fall_p    <= 1'b0;
         bit_end_p <= 1'b0;
      end else begin
         rise_p    <= 1'b0;
         fall_p    <= 1'b0;
         bit_end_p <= 1'b0;
         if (abort) begin
            ph_q    <= PH_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            scl_low <= 1'b0;
         end else begin
            unique case (ph_q)
               PH_IDLE: begin
                  if (start && legal) begin
                     ph_q    <= PH_LOW;
                     scl_low <= 1'b1;
                     fall_p  <= 1'b1;
                     cnt_q   <= low_len - CNT_W'(1);
                     bit_q   <= '0;
                  end
               end
               PH_LOW: begin
                  if (cnt_q == '0) begin
                     ph_q    <= PH_HIGH;
                     scl_low <= 1'b0;
                     rise_p  <= 1'b1;
                     cnt_q   <= high_len - CNT_W'(1);
                  end else begin
                     cnt_q <= cnt_q - CNT_W'(1);
                  end
               end
               PH_HIGH: begin
                  if (cnt_q == '0) begin
                     bit_end_p <= 1'b1;
                     if (bit_q == last_bit) begin
                        ph_q  <= PH_IDLE;
                        bit_q <= '0;
                     end else begin
                        ph_q    <= PH_LOW;
                        scl_low <= 1'b1;
                        fall_p  <= 1'b1;
                        cnt_q   <= low_len - CNT_W'(1);
                        bit_q   <= bit_q + BIT_W'(1);
                     end
                  end else begin
                     cnt_q <= cnt_q - CNT_W'(1);
                  end
               end
               default: ph_q <= PH_IDLE;
            endcase
         end
      end
   end

   assign busy     = (ph_q != PH_IDLE);
   assign ack_slot = busy && (bit_q == BIT_W'(DATA_BITS));

   // R7
   rise_released_chk: assert property (@(posedge clk) disable iff (rst)
      rise_p |-> !scl_low);

   // R7
   fall_pulled_chk: assert property (@(posedge clk) disable iff (rst)
      fall_p |-> scl_low);

   // R7
   pull_marked_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(scl_low) |-> fall_p);

   // R5
   abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
      abort |=> (!busy && !scl_low && !rise_p && !fall_p && !bit_end_p));

   // R4
   no_illegal_run_chk: assert property (@(posedge clk) disable iff (rst)
      busy |-> legal);

   // R6
   ack_slot_en_chk: assert property (@(posedge clk) disable iff (rst)
      ack_slot |-> ack_en);

endmodule

// File: rtl/i2c_sclk_div.sv
module i2c_sclk_div
   import i2c_sclk_pkg::*;
#(
   parameter int CODE_W       = 5,
   parameter int DATA_BITS    = 8,
   parameter int MIN_CODE     = 3,
   parameter int STD_MULT     = 8,
   parameter int FAST_MULT    = 4,
   parameter bit SPECIAL_EN   = 1'b1,
   parameter int SPECIAL_CODE = 5,
   parameter int SPECIAL_LOW  = 6,
   parameter int SPECIAL_HIGH = 4,
   localparam int CTL_W       = CODE_W + 3,
   localparam int MAX_PHASE   = (STD_MULT / 2) * ((1 << CODE_W) - 1),
   localparam int CNT_W       = ceil_log2(MAX_PHASE + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CTL_W-1:0] ctl_wdata,
   input  logic             ctl_we,
   input  logic             xfer_start,
   input  logic             xfer_stop,
   output logic             scl_pull_low,
   output logic             scl_rise_pulse,
   output logic             scl_fall_pulse,
   output logic             bit_done_pulse,
   output logic             xfer_busy,
   output logic             ack_clock_slot,
   output logic             ack_level,
   output logic             cfg_error
);

   logic [CODE_W-1:0] code;
   logic              fast;
   logic              ack_en;
   logic              legal;
   logic [CNT_W-1:0]  low_len;
   logic [CNT_W-1:0]  high_len;

   sclk_ctl_reg #(
      .CODE_W   (CODE_W),
      .MIN_CODE (MIN_CODE)
   ) ctl_i (
      .clk       (clk),
      .rst       (rst),
      .wdata     (ctl_wdata),
      .we        (ctl_we),
      .start_req (xfer_start),
      .code      (code),
      .fast      (fast),
      .ack_lvl   (ack_level),
      .ack_en    (ack_en),
      .legal     (legal),
      .err       (cfg_error)
   );

   sclk_phase_calc #(
      .CODE_W       (CODE_W),
      .STD_MULT     (STD_MULT),
      .FAST_MULT    (FAST_MULT),
      .SPECIAL_EN   (SPECIAL_EN),
      .SPECIAL_CODE (SPECIAL_CODE),
      .SPECIAL_LOW  (SPECIAL_LOW),
      .SPECIAL_HIGH (SPECIAL_HIGH),
      .CNT_W        (CNT_W)
   ) calc_i (
      .code     (code),
      .fast     (fast),
      .low_len  (low_len),
      .high_len (high_len)
   );

   sclk_bit_seq #(
      .DATA_BITS (DATA_BITS),
      .CNT_W     (CNT_W)
   ) seq_i (
      .clk       (clk),
      .rst       (rst),
      .abort     (ctl_we || xfer_stop),
      .start     (xfer_start),
      .legal     (legal),
      .ack_en    (ack_en),
      .low_len   (low_len),
      .high_len  (high_len),
      .scl_low   (scl_pull_low),
      .rise_p    (scl_rise_pulse),
      .fall_p    (scl_fall_pulse),
      .bit_end_p (bit_done_pulse),
      .busy      (xfer_busy),
      .ack_slot  (ack_clock_slot)
   );

   // R8
   stop_release_chk: assert property (@(posedge clk) disable iff (rst)
      xfer_stop |=> (!xfer_busy && !scl_pull_low));

endmodule

// File: tb/i2c_sclk_div_tb_top.sv
module i2c_sclk_div_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] ctl_wdata = '0;
   logic       ctl_we = 1'b0;
   logic       xfer_start = 1'b0;
   logic       xfer_stop = 1'b0;
   logic       scl_pull_low, scl_rise_pulse, scl_fall_pulse, bit_done_pulse;
   logic       xfer_busy, ack_clock_slot, ack_level, cfg_error;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   i2c_sclk_div dut_i (
      .clk            (clk),
      .rst            (rst),
      .ctl_wdata      (ctl_wdata),
      .ctl_we         (ctl_we),
      .xfer_start     (xfer_start),
      .xfer_stop      (xfer_stop),
      .scl_pull_low   (scl_pull_low),
      .scl_rise_pulse (scl_rise_pulse),
      .scl_fall_pulse (scl_fall_pulse),
      .bit_done_pulse (bit_done_pulse),
      .xfer_busy      (xfer_busy),
      .ack_clock_slot (ack_clock_slot),
      .ack_level      (ack_level),
      .cfg_error      (cfg_error)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic write_ctl(input logic [7:0] v);
      @(negedge clk);
      ctl_wdata = v;
      ctl_we    = 1'b1;
      @(negedge clk);
      ctl_we    = 1'b0;
   endtask

   // drives start; returns at the negedge right after the edge that took it
   task automatic pulse_start();
      @(negedge clk);
      xfer_start = 1'b1;
      @(negedge clk);
      xfer_start = 1'b0;
   endtask

   task automatic t_reset();
      chk("R10 busy", int'(xfer_busy), 0);
      chk("R10 scl", int'(scl_pull_low), 0);
      chk("R10 pulses", int'(scl_rise_pulse | scl_fall_pulse | bit_done_pulse), 0);
      chk("R10 err", int'(cfg_error), 0);
      chk("R10 ack_level", int'(ack_level), 0);
   endtask

   task automatic t_byte(input bit fast, input int code, input bit ack);
      int exp_l, exp_h, nb;
      int falls = 0, rises = 0, ends = 0, lowc = 0, highc = 0, first_low = 0, acks = 0;
      string tag;
      if (!fast) begin
         exp_l = 4 * code; exp_h = 4 * code; tag = "R1";
      end else if (code == 5) begin
         exp_l = 6; exp_h = 4; tag = "R3";
      end else begin
         exp_l = 2 * code; exp_h = 2 * code; tag = "R2";
      end
      nb = ack ? 9 : 8;
      write_ctl({ack, 1'b0, fast, 5'(code)});
      pulse_start();
      chk("R7 first fall", int'(scl_fall_pulse), 1);
      for (int i = 0; i < 5000; i++) begin
         if (scl_fall_pulse) falls++;
         if (scl_rise_pulse) rises++;
         if (bit_done_pulse) ends++;
         if (ack_clock_slot) acks++;
         if (xfer_busy && scl_pull_low) lowc++;
         if (xfer_busy && !scl_pull_low) highc++;
         if (rises == 0 && scl_pull_low) first_low++;
         if (!xfer_busy) break;
         @(negedge clk);
      end
      $display("mode fast=%0d code=%0d ack=%0d", fast, code, ack);
      chk({tag, " first low run"}, first_low, exp_l);
      chk({tag, " low total"}, lowc, nb * exp_l);
      chk({tag, " high total"}, highc, nb * exp_h);
      chk("R6 clock count", rises, nb);
      chk("R7 falls", falls, nb);
      chk("R7 bit ends", ends, nb);
      chk("R6 ack slot cycles", acks, ack ? exp_l + exp_h : 0);
      chk("R6 released at end", int'(scl_pull_low), 0);
   endtask

   task automatic t_illegal();
      write_ctl(8'h02);
      chk("R4 err on write", int'(cfg_error), 1);
      pulse_start();
      chk("R4 no start", int'(xfer_busy), 0);
      chk("R4 scl released", int'(scl_pull_low), 0);
      repeat (5) @(negedge clk);
      chk("R4 err sticky", int'(cfg_error), 1);
      write_ctl(8'h00);
      chk("R4 err after illegal rewrite", int'(cfg_error), 1);
      write_ctl(8'h05);
      chk("R4 err cleared", int'(cfg_error), 0);
   endtask

   task automatic t_reset_start_err();
      pulse_start();
      chk("R4 start at code 0 sets err", int'(cfg_error), 1);
      chk("R4 start at code 0 idle", int'(xfer_busy), 0);
   endtask

   task automatic t_abort_mid();
      int p = 0;
      write_ctl(8'h06);
      pulse_start();
      repeat (29) @(negedge clk);
      chk("R5 running before write", int'(xfer_busy), 1);
      ctl_wdata = 8'h06;
      ctl_we = 1'b1;
      @(negedge clk);
      ctl_we = 1'b0;
      chk("R5 busy after write", int'(xfer_busy), 0);
      chk("R5 scl after write", int'(scl_pull_low), 0);
      for (int i = 0; i < 60; i++) begin
         if (scl_rise_pulse || scl_fall_pulse || bit_done_pulse) p++;
         @(negedge clk);
      end
      chk("R5 no pulses after write", p, 0);
   endtask

   task automatic t_collide_boundary();
      write_ctl(8'h23);
      pulse_start();
      repeat (11) @(negedge clk);
      chk("R5 high phase before boundary", int'(scl_pull_low), 0);
      ctl_wdata = 8'h23;
      ctl_we = 1'b1;
      @(negedge clk);
      ctl_we = 1'b0;
      chk("R5 boundary bit_done suppressed", int'(bit_done_pulse), 0);
      chk("R5 boundary fall suppressed", int'(scl_fall_pulse), 0);
      chk("R5 boundary idle", int'(xfer_busy), 0);
      chk("R5 boundary scl", int'(scl_pull_low), 0);
   endtask

   task automatic t_collide_start();
      @(negedge clk);
      ctl_wdata = 8'h25;
      ctl_we = 1'b1;
      xfer_start = 1'b1;
      @(negedge clk);
      ctl_we = 1'b0;
      xfer_start = 1'b0;
      chk("R5 write beats start", int'(xfer_busy), 0);
      chk("R5 write beats start scl", int'(scl_pull_low), 0);
   endtask

   task automatic t_stop();
      write_ctl(8'h04);
      pulse_start();
      repeat (6) @(negedge clk);
      xfer_stop = 1'b1;
      @(negedge clk);
      xfer_stop = 1'b0;
      chk("R8 idle after stop", int'(xfer_busy), 0);
      chk("R8 scl after stop", int'(scl_pull_low), 0);
   endtask

   task automatic t_level();
      write_ctl(8'h45);
      chk("R9 level high", int'(ack_level), 1);
      write_ctl(8'h05);
      chk("R9 level low", int'(ack_level), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_reset_start_err();
      t_illegal();
      t_byte(1'b0, 3, 1'b0);
      t_byte(1'b0, 5, 1'b1);
      t_byte(1'b0, 6, 1'b0);
      t_byte(1'b0, 31, 1'b1);
      t_byte(1'b1, 3, 1'b1);
      t_byte(1'b1, 5, 1'b0);
      t_byte(1'b1, 5, 1'b1);
      t_byte(1'b1, 6, 1'b0);
      t_byte(1'b1, 31, 1'b1);
      t_abort_mid();
      t_collide_boundary();
      t_collide_start();
      t_stop();
      t_level();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule